// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Write Engine

This block turns one 64-bit send command into a single 32-bit store into the register space of a chosen target core. The command's upper half is the payload. A four-bit keep field in the lower half marks bytes of the existing target word that must survive. When any of those bits is set, the engine reads the target word first, merges it byte by byte with the payload, and then writes the result. When none is set, it skips the read and stores the payload as it stands.

Two command kinds are decoded from the low 12 bits of the command's register address. A mailbox send builds its target address from a fixed mailbox base plus a small slot field. An arbitrary send takes its full 16-bit target address from the command. Toward the target the block drives a read port and a write port. Each port uses request/acknowledge, and both carry the target core number with them. While a transaction is open, `busy_o` holds back any new command. A command that names a core outside the configured range is dropped and reported with a one-cycle error pulse.

Top module: `mbx_write_engine`

## Requirements
- R1: A command is taken only when `cmd_valid_i` is high, `cmd_full_i` is high (64-bit access), `cmd_off_i` equals `MBX_OFF` (0x048, mailbox) or `ANY_OFF` (0x158, arbitrary), and `busy_o` is low. Any other command starts no request and leaves `busy_o` low.
- R2: `core_id_o` shows command bits 25:16 of the accepted command and holds steady for the whole transaction.
- R3: For a mailbox send, the target address is 0x1020 + (command[15:0] & 0x001C).
- R4: For an arbitrary send, the target address is command bits 15:0.
- R5: When keep bits 30:27 are all zero, no read request is issued and the written word is command bits 63:32.
- R6: When any keep bit is set, one read of the target address comes first. Written byte i (bits 8i+7:8i) is the read byte if command bit 27+i is set; otherwise it is command bits 32+8i+7:32+8i.
- R7: A read or write request stays high, with a stable address, until its acknowledge. Read and write requests are never high together, and the write follows the read.
- R8: `busy_o` rises on the edge that accepts a command and falls one cycle after `done_o`. `done_o` is a one-cycle pulse in the cycle after the write acknowledge.
- R9: A command with a core number of `NUM_CORES` (8) or more raises `err_o` for exactly one cycle after acceptance. It issues no request and `busy_o` stays low. Core `NUM_CORES`-1 is served normally.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `rd_req_o` and `wr_req_o` are low, and `core_id_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_full_i | input | 1 | High when the access is a full 64-bit write |
| cmd_off_i | input | 12 | Register offset of the command write |
| cmd_data_i | input | 64 | Command word |
| busy_o | output | 1 | Transaction open, new commands held off |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a dropped out-of-range core |
| core_id_o | output | 10 | Target core of the open transaction |
| rd_req_o | output | 1 | Read request to the target |
| rd_addr_o | output | 16 | Read address |
| rd_ack_i | input | 1 | Read acknowledge, qualifies rd_data_i |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request to the target |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 32 | Merged write data |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
Two events can coincide at the command port: a new command arriving while the engine is finishing the previous one, and a write acknowledge for the transaction still open. The bench holds a second command valid across the first command's whole lifetime, including its done cycle. It then checks that the target sees the first write with the first payload, and that the second command is taken only after `busy_o` falls and produces its own correct write. A read acknowledge held back for several cycles, followed by a merge, confirms that the read data is sampled only on the acknowledging edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CMD_W   = 64;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 16;
  localparam int CORE_W  = 10;
  localparam int OFF_W   = 12;
  localparam int BYTES   = WORD_W / 8;
  localparam int CORE_LO = 16;
  localparam int KEEP_LO = 27;
  localparam int DATA_LO = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  keep;
    logic [WORD_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int               NUM_CORES = 8,
  parameter logic [OFF_W-1:0]  MBX_OFF   = 12'h048,
  parameter logic [OFF_W-1:0]  ANY_OFF   = 12'h158,
  parameter logic [ADDR_W-1:0] MBX_BASE  = 16'h1020,
  parameter logic [ADDR_W-1:0] MBX_SEL   = 16'h001C
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CMD_W-1:0] data_i,
  output logic             hit_o,
  output logic             core_ok_o,
  output cmd_t             cmd_o
);
  localparam logic [CORE_W-1:0] CORE_LIM = CORE_W'(NUM_CORES);

  logic              hit_mbx, hit_any;
  logic [ADDR_W-1:0] low;
  logic              unused_bits;

  assign hit_mbx = (off_i == MBX_OFF);
  assign hit_any = (off_i == ANY_OFF);
  assign hit_o   = hit_mbx | hit_any;
  assign low     = data_i[ADDR_W-1:0];

  assign cmd_o.core = data_i[CORE_LO +: CORE_W];
  assign cmd_o.keep = data_i[KEEP_LO +: BYTES];
  assign cmd_o.data = data_i[DATA_LO +: WORD_W];
  // mailbox slots are word aligned inside a small window
  assign cmd_o.addr = hit_mbx ? (MBX_BASE + (low & MBX_SEL)) : low;

  assign core_ok_o   = (cmd_o.core < CORE_LIM);
  assign unused_bits = ^{data_i[31], data_i[26]};
endmodule

// File: rtl/mbx_byte_merge.sv
module mbx_byte_merge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] new_i,
  input  logic [BYTES-1:0]  keep_i,
  output logic [WORD_W-1:0] out_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign out_o[8*b +: 8] = keep_i[b] ? old_i[8*b +: 8] : new_i[8*b +: 8];
  end
endmodule

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
  import mbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic need_rd_i,
  input  logic rd_ack_i,
  input  logic wr_ack_i,
  output logic idle_o,
  output logic rd_req_o,
  output logic rd_take_o,
  output logic wr_req_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = need_rd_i ? ST_RD_REQ : ST_WR_REQ;
      ST_RD_REQ:  state_d = rd_ack_i ? ST_WR_REQ : ST_RD_WAIT;
      ST_RD_WAIT: if (rd_ack_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  state_d = wr_ack_i ? ST_DONE : ST_WR_WAIT;
      ST_WR_WAIT: if (wr_ack_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign rd_req_o  = (state_q == ST_RD_REQ) | (state_q == ST_RD_WAIT);
  assign wr_req_o  = (state_q == ST_WR_REQ) | (state_q == ST_WR_WAIT);
  assign rd_take_o = rd_req_o & rd_ack_i;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/mbx_write_engine.sv
module mbx_write_engine
  import mbx_pkg::*;
#(
  parameter int               NUM_CORES = 8,
  parameter logic [OFF_W-1:0]  MBX_OFF   = 12'h048,
  parameter logic [OFF_W-1:0]  ANY_OFF   = 12'h158,
  parameter logic [ADDR_W-1:0] MBX_BASE  = 16'h1020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_full_i,
  input  logic [OFF_W-1:0]  cmd_off_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CORE_W-1:0] core_id_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              wr_ack_i
);
  cmd_t              dec_cmd, cmd_q;
  logic              hit, core_ok, idle, accept, start, rd_take;
  logic              err_q;
  logic [WORD_W-1:0] merged, wdata_q;

  mbx_cmd_decode #(
    .NUM_CORES(NUM_CORES), .MBX_OFF(MBX_OFF), .ANY_OFF(ANY_OFF), .MBX_BASE(MBX_BASE)
  ) u_dec (
    .off_i(cmd_off_i), .data_i(cmd_data_i),
    .hit_o(hit), .core_ok_o(core_ok), .cmd_o(dec_cmd)
  );

  assign accept = cmd_valid_i & cmd_full_i & hit & idle;
  assign start  = accept & core_ok;

  mbx_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .need_rd_i(|dec_cmd.keep),
    .rd_ack_i, .wr_ack_i,
    .idle_o(idle), .rd_req_o, .rd_take_o(rd_take), .wr_req_o, .done_o
  );

  mbx_byte_merge u_merge (
    .old_i(rd_data_i), .new_i(cmd_q.data), .keep_i(cmd_q.keep), .out_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept & ~core_ok;
      if (start) begin
        cmd_q   <= dec_cmd;
        wdata_q <= dec_cmd.data;
      end else if (rd_take) begin
        wdata_q <= merged;
      end
    end
  end

  assign busy_o    = ~idle;
  assign err_o     = err_q;
  assign core_id_o = cmd_q.core;
  assign rd_addr_o = cmd_q.addr;
  assign wr_addr_o = cmd_q.addr;
  assign wr_data_o = wdata_q;
endmodule

// File: rtl/mbx_write_engine_chk.sv
module mbx_write_engine_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [CORE_W-1:0] core_id_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              wr_ack_i
);
  assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  assert_wr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o));
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  assert_rd_then_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> wr_req_o);
  assert_core_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(core_id_o));
  assert_req_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || wr_req_o) |-> busy_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rd_req_o && !wr_req_o && !busy_o);
  assert_core_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> core_id_o < CORE_W'(NUM_CORES));
endmodule

bind mbx_write_engine mbx_write_engine_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .core_id_o(core_id_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
  .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_ack_i(wr_ack_i)
);

// File: tb/tb_mbx_write_engine.sv
`timescale 1ns/1ps
module tb_mbx_write_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_full = 1'b0;
  logic [11:0] cmd_off = '0;
  logic [63:0] cmd_data = '0;
  logic        busy, done, err, rd_req, rd_ack = 1'b0, wr_req, wr_ack = 1'b0;
  logic [9:0]  core_id;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] rd_data = '0, wr_data;

  int checks = 0, errors = 0;
  int rd_lat = 0, rd_cnt = 0, n_rd = 0, n_wr = 0;
  logic [15:0] log_addr [8];
  logic [31:0] log_data [8];
  logic [9:0]  log_core [8];
  bit err_seen, done_seen, busy_seen, finished = 0;

  localparam logic [11:0] OFF_MBX = 12'h048, OFF_ANY = 12'h158;

  always #4 clk = ~clk;

  mbx_write_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_full_i(cmd_full),
    .cmd_off_i(cmd_off), .cmd_data_i(cmd_data), .busy_o(busy), .done_o(done),
    .err_o(err), .core_id_o(core_id), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_ack_i(wr_ack)
  );

  function automatic logic [31:0] oldv(logic [15:0] a);
    return {a, a ^ 16'h5A3C};
  endfunction

  function automatic logic [63:0] mk(logic [31:0] d, logic [3:0] k, logic [9:0] c, logic [15:0] lo);
    return {d, 1'b0, k, 1'b0, c, lo};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] k);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = k[b] ? o[8*b +: 8] : n[8*b +: 8];
    return r;
  endfunction

  // target-side responder
  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      if (rd_cnt == rd_lat) begin
        rd_ack = 1'b1; rd_data = oldv(rd_addr); rd_cnt = 0; n_rd++;
      end else rd_cnt++;
    end else begin
      rd_ack = 1'b0; rd_data = 32'hxxxx_xxxx;
    end
    if (wr_req && !wr_ack) begin
      wr_ack = 1'b1;
      if (n_wr < 8) begin
        log_addr[n_wr] = wr_addr; log_data[n_wr] = wr_data; log_core[n_wr] = core_id;
      end
      n_wr++;
    end else wr_ack = 1'b0;
    if (err) err_seen = 1;
    if (done) done_seen = 1;
    if (busy) busy_seen = 1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    err_seen = 0; done_seen = 0; busy_seen = 0; n_rd = 0; n_wr = 0;
  endtask

  task automatic send(logic full, logic [11:0] off, logic [63:0] d);
    @(negedge clk);
    clear_flags();
    cmd_valid = 1'b1; cmd_full = full; cmd_off = off; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done_seen || !busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 busy", busy, 0); check("R10 done", done, 0); check("R10 err", err, 0);
    check("R10 rd_req", rd_req, 0); check("R10 wr_req", wr_req, 0);
    check("R10 core", core_id, 0);
  endtask

  task automatic t_mbx_plain();
    send(1, OFF_MBX, mk(32'hDEADBEEF, 4'h0, 10'd3, 16'hFFF7));
    check("R5 no read", n_rd, 0);
    check("R8 one write", n_wr, 1);
    check("R3 mbx addr", log_addr[0], 16'h1020 + (16'hFFF7 & 16'h001C));
    check("R5 data", log_data[0], 32'hDEADBEEF);
    check("R2 core", log_core[0], 3);
    check("R8 done", done_seen, 1);
    check("R8 busy low after", busy, 0);
  endtask

  task automatic t_any_keep();
    send(1, OFF_ANY, mk(32'h11223344, 4'b0101, 10'd5, 16'h2468));
    check("R6 one read", n_rd, 1);
    check("R4 any addr", log_addr[0], 16'h2468);
    check("R6 merge", log_data[0], merge(oldv(16'h2468), 32'h11223344, 4'b0101));
    check("R2 core", log_core[0], 5);
  endtask

  task automatic t_keep_all_slow();
    rd_lat = 3;
    send(1, OFF_MBX, mk(32'hCAFEF00D, 4'b1111, 10'd7, 16'h001C));
    rd_lat = 0;
    check("R7 one read", n_rd, 1);
    check("R3 top slot", log_addr[0], 16'h103C);
    check("R6 keep all", log_data[0], oldv(16'h103C));
    check("R9 last core ok", log_core[0], 7);
    send(1, OFF_ANY, mk(32'hA0B1C2D3, 4'b1000, 10'd1, 16'h0004));
    check("R6 keep top byte", log_data[0], merge(oldv(16'h0004), 32'hA0B1C2D3, 4'b1000));
  endtask

  task automatic t_bad_core();
    send(1, OFF_ANY, mk(32'h12345678, 4'b0011, 10'd8, 16'h0100));
    check("R9 err pulse", err_seen, 1);
    check("R9 no write", n_wr, 0);
    check("R9 no read", n_rd, 0);
    check("R9 never busy", busy_seen, 0);
    send(1, OFF_MBX, mk(32'h12345678, 4'b0000, 10'h3FF, 16'h0000));
    check("R9 err high core", err_seen, 1);
    check("R9 no write high core", n_wr, 0);
  endtask

  task automatic t_ignore();
    send(0, OFF_MBX, mk(32'h55555555, 4'h0, 10'd2, 16'h0000));
    check("R1 half width ignored", n_wr + n_rd, 0);
    check("R1 half width not busy", busy_seen, 0);
    send(1, 12'h050, mk(32'h55555555, 4'h0, 10'd2, 16'h0000));
    check("R1 wrong offset ignored", n_wr + n_rd, 0);
    check("R1 wrong offset not busy", busy_seen, 0);
    check("R1 no err", err_seen, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    clear_flags();
    rd_lat = 2;
    cmd_valid = 1'b1; cmd_full = 1'b1; cmd_off = OFF_ANY;
    cmd_data = mk(32'h0BADCAFE, 4'b0010, 10'd4, 16'h0300);
    @(negedge clk);
    check("R8 busy after accept", busy, 1);
    cmd_off = OFF_MBX;
    cmd_data = mk(32'h77665544, 4'b0000, 10'd6, 16'h0008);
    for (int i = 0; i < 30; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check("R1 held while busy", n_wr, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rd_lat = 0;
    check("R8 two writes", n_wr, 2);
    check("R6 first merge", log_data[0], merge(oldv(16'h0300), 32'h0BADCAFE, 4'b0010));
    check("R2 first core", log_core[0], 4);
    check("R3 second addr", log_addr[1], 16'h1028);
    check("R5 second data", log_data[1], 32'h77665544);
    check("R2 second core", log_core[1], 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mbx_plain();
    t_any_keep();
    t_keep_all_slow();
    t_bad_core();
    t_ignore();
    t_back_to_back();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule